// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel byte into an asynchronous serial character on a single transmit line. The shape of each character comes from an 8-bit line-control value: how many data bits are sent (five to eight), whether a parity bit follows them and how that bit is formed (odd, even, or held at a constant level), and how long the closing stop period lasts. A separate control bit holds the line low to signal a break to the far end.

Bytes arrive over a valid/ready handshake. The framer accepts a byte only while it is idle, captures the line-control value together with the byte, and starts the character on the next pulse of a baud enable that runs at sixteen times the bit rate. Every bit period is counted in those pulses. Because the control value is captured at acceptance, software may rewrite it while a character is on the line without damaging that character. The break control is the one exception: it acts on the live control input at once.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no character is in progress and break is off, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Control bits [1:0] set the data bit count (00 = 5, 01 = 6, 10 = 7, 11 = 8); data bits are sent least significant first, and byte bits above the count are not sent.
- R3: A character starts with `txd` = 0 on the first `tick` edge after the byte is accepted; the start bit and every data or parity bit last exactly 16 ticks.
- R4: Control bit 3 = 1 appends one parity bit after the data bits; bit 3 = 0 sends no parity bit.
- R5: With bit 3 = 1 and bit 5 = 0, bit 4 = 0 makes the number of ones over the sent data bits plus parity odd, and bit 4 = 1 makes it even.
- R6: With bit 3 = 1 and bit 5 = 1, the parity bit is 1 when bit 4 = 0 and 0 when bit 4 = 1, whatever the data.
- R7: Control bit 2 = 0 gives a 16-tick stop period; bit 2 = 1 gives 24 ticks for a 5-bit word and 32 ticks for 6 to 8 bits. `txd` is 1 during the stop period and `busy` falls on the tick that ends it.
- R8: While live control bit 6 is 1, `txd` is 0 in every cycle; a character in progress keeps its timing, so `busy` falls when it would have without the break.
- R9: `in_ready` is 1 only when no character is pending or in progress; a byte is taken on a clock edge with `in_valid` and `in_ready` both 1, and `busy` is 1 from the next cycle until the stop period ends.
- R10: The control value is captured with the byte; changes to control bits 0 to 5 after acceptance do not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Baud enable, one pulse per 1/16 bit period |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| line_ctrl | input | 8 | Frame format and break control |
| in_ready | output | 1 | Framer can take a byte |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A character is pending or on the line |

## Verification
The bench aims at the stop length that depends on word length (a design that ignored the 5-bit case would stretch 1.5 stop bits to 2 and drop `busy` 8 ticks late) and at parity, where swapped odd/even sense, a constant level tied the wrong way, or a parity sum that included unsent high byte bits would each flip the parity bit on chosen patterns. It rewrites the control input right after acceptance, so a design that read the live value mid-character would change bit count or parity. Break is raised in the middle of a character: a design that paused its counters during break would end the character late, and one that latched break with the byte would not pull the line low at once.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  // Sequencer phases of one character
  typedef enum logic [2:0] {
    TXF_IDLE   = 3'd0,
    TXF_START  = 3'd1,
    TXF_DATA   = 3'd2,
    TXF_PARITY = 3'd3,
    TXF_STOP   = 3'd4
  } txf_state_e;

  // Line-control byte; field positions are decoded by software, so they stay fixed
  typedef struct packed {
    logic       spare;      // bit 7, not used by the framer
    logic       brk;        // bit 6, hold line low
    logic       stick;      // bit 5, constant parity level
    logic       even;       // bit 4, parity sense
    logic       par_en;     // bit 3, parity bit present
    logic       long_stop;  // bit 2, extended stop period
    logic [1:0] wlen;       // bits 1:0, word length code
  } txf_cfg_t;

  localparam int unsigned TXF_MIN_WORD = 5;

endpackage

// File: rtl/txf_hold.sv
module txf_hold
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [7:0]        line_ctrl,
  input  logic              idle,
  input  logic              launch,
  output logic              in_ready,
  output logic              pending,
  output logic [DATA_W-1:0] data_q,
  output txf_cfg_t          cfg_q
);

  logic              en_q, en_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] data_d;
  txf_cfg_t          cfg_d;
  logic              accept;

  assign in_ready = en_q & idle & ~pend_q;
  assign accept   = in_valid & in_ready;

  always_comb begin
    en_d   = 1'b1;
    pend_d = pend_q;
    data_d = data_q;
    cfg_d  = cfg_q;
    if (accept) begin
      pend_d = 1'b1;
      data_d = in_data;
      cfg_d  = txf_cfg_t'(line_ctrl);
    end else if (launch) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      data_q <= data_d;
      cfg_q  <= cfg_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/txf_decode.sv
module txf_decode
  import uart_txf_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int NB_W   = 4
) (
  input  txf_cfg_t          cfg,
  input  logic [DATA_W-1:0] data,
  output logic [NB_W-1:0]   nbits,
  output logic [CNT_W-1:0]  stop_len,
  output logic              par_bit
);

  localparam logic [CNT_W-1:0] ONE_STOP  = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] HALF_STOP = CNT_W'(OSR + OSR / 2);
  localparam logic [CNT_W-1:0] TWO_STOP  = CNT_W'(2 * OSR);

  logic [DATA_W-1:0] masked;
  logic              ones_odd;
  logic              unused_cfg;

  assign nbits = NB_W'(TXF_MIN_WORD) + NB_W'(cfg.wlen);

  // keep only the bits that go on the line
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (nbits > NB_W'(i));
  end

  assign ones_odd = ^masked;

  always_comb begin
    if (cfg.stick)     par_bit = ~cfg.even;
    else if (cfg.even) par_bit = ones_odd;
    else               par_bit = ~ones_odd;
  end

  always_comb begin
    if (!cfg.long_stop)     stop_len = ONE_STOP;
    else if (cfg.wlen == 0) stop_len = HALF_STOP;
    else                    stop_len = TWO_STOP;
  end

  assign unused_cfg = ^{cfg.spare, cfg.brk, cfg.par_en};

endmodule

// File: rtl/txf_seq.sv
module txf_seq
  import uart_txf_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = 6,
  parameter int NB_W  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pending,
  input  logic [NB_W-1:0]  nbits,
  input  logic [CNT_W-1:0] stop_len,
  input  logic             par_en,
  output txf_state_e       state,
  output logic [IDX_W-1:0] bit_idx,
  output logic             launch,
  output logic             idle
);

  localparam logic [CNT_W-1:0] BIT_LEN = CNT_W'(OSR);

  txf_state_e       state_q, state_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic [IDX_W-1:0] bidx_q, bidx_d;
  logic [CNT_W-1:0] phase_len;
  logic             phase_end;
  logic             last_bit;

  assign phase_len = (state_q == TXF_STOP) ? stop_len : BIT_LEN;
  assign phase_end = tick & (tcnt_q == phase_len - 1'b1);
  assign last_bit  = (NB_W'(bidx_q) == nbits - 1'b1);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    launch  = 1'b0;
    if (tick && state_q != TXF_IDLE) begin
      tcnt_d = phase_end ? '0 : tcnt_q + 1'b1;
    end
    unique case (state_q)
      TXF_IDLE: begin
        if (tick && pending) begin
          state_d = TXF_START;
          tcnt_d  = '0;
          launch  = 1'b1;
        end
      end
      TXF_START: begin
        if (phase_end) begin
          state_d = TXF_DATA;
          bidx_d  = '0;
        end
      end
      TXF_DATA: begin
        if (phase_end) begin
          if (last_bit) state_d = par_en ? TXF_PARITY : TXF_STOP;
          else          bidx_d  = bidx_q + 1'b1;
        end
      end
      TXF_PARITY: begin
        if (phase_end) state_d = TXF_STOP;
      end
      TXF_STOP: begin
        if (phase_end) state_d = TXF_IDLE;
      end
      default: state_d = TXF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXF_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
    end
  end

  assign state   = state_q;
  assign bit_idx = bidx_q;
  assign idle    = (state_q == TXF_IDLE);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [7:0]        line_ctrl,
  output logic              in_ready,
  output logic              txd,
  output logic              busy
);

  localparam int CNT_W = $clog2(2 * OSR + 1);
  localparam int NB_W  = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  logic              pending, launch, idle;
  logic [DATA_W-1:0] data_q;
  txf_cfg_t          cfg_q;
  txf_state_e        state;
  logic [IDX_W-1:0]  bit_idx;
  logic [NB_W-1:0]   nbits;
  logic [CNT_W-1:0]  stop_len;
  logic              par_bit;
  logic              frame_lvl;
  txf_cfg_t          live_cfg;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  txf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .line_ctrl(line_ctrl),
    .idle     (idle),
    .launch   (launch),
    .in_ready (in_ready),
    .pending  (pending),
    .data_q   (data_q),
    .cfg_q    (cfg_q)
  );

  txf_decode #(.OSR(OSR), .DATA_W(DATA_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_dec (
    .cfg     (cfg_q),
    .data    (data_q),
    .nbits   (nbits),
    .stop_len(stop_len),
    .par_bit (par_bit)
  );

  txf_seq #(.OSR(OSR), .CNT_W(CNT_W), .NB_W(NB_W), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick),
    .pending (pending),
    .nbits   (nbits),
    .stop_len(stop_len),
    .par_en  (cfg_q.par_en),
    .state   (state),
    .bit_idx (bit_idx),
    .launch  (launch),
    .idle    (idle)
  );

  always_comb begin
    unique case (state)
      TXF_START:  frame_lvl = 1'b0;
      TXF_DATA:   frame_lvl = data_q[bit_idx];
      TXF_PARITY: frame_lvl = par_bit;
      default:    frame_lvl = 1'b1;
    endcase
  end

  // break acts on the live control value, not the captured one
  assign live_cfg = txf_cfg_t'(line_ctrl);
  assign txd      = frame_lvl & ~live_cfg.brk;
  assign busy     = pending | ~idle;

endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] line_ctrl,
  input logic       txd,
  input logic       busy
);

  // R9: an accepted byte makes the framer busy on the next cycle
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R9: busy only rises because a byte was taken
  a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  // R1: idle line sits high when no break is requested
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_ctrl[6]) |-> txd);

  // R8: break holds the line low
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctrl[6] |-> !txd);

  // R3: the line only changes on baud ticks, so a falling edge follows a tick
  a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && !line_ctrl[6] && !$past(line_ctrl[6])) |-> $past(tick));

endmodule

bind uart_tx_framer txf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .line_ctrl(line_ctrl),
  .txd      (txd),
  .busy     (busy)
);

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       in_valid;
  logic [7:0] in_data;
  logic [7:0] line_ctrl;
  logic       in_ready;
  logic       txd;
  logic       busy;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  uart_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_data(in_data), .line_ctrl(line_ctrl), .in_ready(in_ready),
    .txd(txd), .busy(busy)
  );

  // baud enable every third clock, changed away from the active edge
  initial begin
    int div = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      div  = (div == 2) ? 0 : div + 1;
      tick = (div == 0);
    end
  end

  logic tick_at_edge = 1'b0;
  always @(posedge clk) tick_at_edge <= tick;

  typedef struct {
    logic [11:0] bits;
    int          nb;
    int          nt;
    string       tag;
  } frame_t;

  frame_t q[$];
  frame_t cur;
  bit     in_frame = 0;
  bit     mon_en   = 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic frame_t build(input logic [7:0] d, input logic [7:0] lcr,
                                   input string tag);
    frame_t f;
    int     nd;
    int     stp;
    logic   x;
    nd = 5 + int'(lcr[1:0]);
    x  = 1'b0;
    f.bits = '0;
    for (int i = 0; i < nd; i++) begin
      x = x ^ d[i];
      f.bits[1 + i] = d[i];
    end
    f.nb = 1 + nd;
    if (lcr[3]) begin
      if (lcr[5])      f.bits[f.nb] = ~lcr[4];
      else if (lcr[4]) f.bits[f.nb] = x;
      else             f.bits[f.nb] = ~x;
      f.nb++;
    end
    if (!lcr[2])      stp = 16;
    else if (nd == 5) stp = 24;
    else              stp = 32;
    f.nt  = 16 * f.nb + stp;
    f.tag = tag;
    return f;
  endfunction

  // monitor: one sample after every tick edge, compared with the expected level
  initial begin
    int s = 0;
    int bad_s = -1;
    int bad_v = 0;
    int bad_e = 0;
    forever begin
      @(negedge clk);
      if (tick_at_edge && mon_en) begin
        if (!in_frame) begin
          if (txd === 1'b0) begin
            if (q.size() == 0) begin
              chk(1'b0, "R9", "unexpected character start", 0, 1);
            end else begin
              cur      = q.pop_front();
              in_frame = 1;
              s        = 0;
              bad_s    = -1;
            end
          end
        end else begin
          s++;
        end
        if (in_frame) begin
          if (s < cur.nt) begin
            int   e;
            e = ((s / 16) < cur.nb) ? int'(cur.bits[s / 16]) : 1;
            if (bad_s < 0 && (txd !== e[0] || busy !== 1'b1)) begin
              bad_s = s;
              bad_v = int'(txd);
              bad_e = e;
            end
          end else begin
            if (bad_s < 0 && (busy !== 1'b0 || txd !== 1'b1)) begin
              bad_s = s;
              bad_v = int'(busy);
              bad_e = 0;
            end
            chk(bad_s < 0, cur.tag,
                $sformatf("frame level/busy at tick %0d", bad_s), bad_v, bad_e);
            in_frame = 0;
          end
        end
      end
    end
  end

  // driver: queue the expectation, offer the byte, follow the handshake
  task automatic send(input logic [7:0] d, input logic [7:0] lcr,
                      input logic [7:0] after_lcr, input string tag, input bit push);
    @(negedge clk);
    if (push) q.push_back(build(d, lcr, tag));
    in_valid  = 1'b1;
    in_data   = d;
    line_ctrl = lcr;
    while (in_ready !== 1'b1) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    in_data   = 8'h00;
    line_ctrl = after_lcr;
    // R9: no second byte taken once busy; R3: line still high until the next tick
    chk(in_ready === 1'b0 && busy === 1'b1, "R9", "ready/busy after accept",
        int'({in_ready, busy}), 1);
    chk(txd === 1'b1, "R3", "line before first tick", int'(txd), 1);
    do @(negedge clk); while (!tick_at_edge);
    chk(txd === 1'b0, "R3", "start bit on first tick", int'(txd), 0);
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0 || busy || in_frame);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = 8'h00;
    line_ctrl = 8'h00;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0, "R1", "line/busy in reset",
        int'({txd, busy}), 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
        "idle after reset", int'({txd, busy, in_ready}), 5);

    // R2 R3 R7: 8 data bits, no parity, one stop
    send(8'hA5, 8'h03, 8'h03, "R2 R4 8N1", 1);
    drain();
    // R2: 5-bit word, upper byte bits not sent
    send(8'hFF, 8'h00, 8'h00, "R2 5-bit", 1);
    drain();
    // R4 R5: 6 bits, odd parity; only low 6 bits count
    send(8'hEC, 8'h09, 8'h09, "R5 odd 6-bit", 1);
    drain();
    // R5: 7 bits, even parity
    send(8'h55, 8'h1A, 8'h1A, "R5 even 7-bit", 1);
    drain();
    // R6: constant parity 1, then constant 0
    send(8'h01, 8'h2B, 8'h2B, "R6 stick one", 1);
    drain();
    send(8'hFE, 8'h3B, 8'h3B, "R6 stick zero", 1);
    drain();
    // R7: 1.5 stop for 5 bits, 2 stop for 8 bits, 2 stop for 6 bits with parity
    send(8'h0A, 8'h04, 8'h04, "R7 5-bit long stop", 1);
    drain();
    send(8'h3C, 8'h07, 8'h07, "R7 8-bit long stop", 1);
    drain();
    send(8'h15, 8'h0D, 8'h0D, "R7 6-bit parity long stop", 1);
    drain();
    // R10: rewrite control right after acceptance
    send(8'h0F, 8'h03, 8'h3C, "R10 control rewrite", 1);
    drain();
    // R9 R10: back-to-back, second offer waits while the first is on the line
    send(8'hC3, 8'h1B, 8'h1B, "R9 first of pair", 1);
    send(8'h5A, 8'h0E, 8'h0E, "R9 second of pair", 1);
    drain();

    // R8: break raised mid-character; timing of the character must not change
    mon_en = 0;
    begin
      int s = 0;
      int bad = 0;
      send(8'h96, 8'h03, 8'h03, "R8", 0);
      while (s < 400) begin
        do @(negedge clk); while (!tick_at_edge);
        s++;
        if (s > 40 && s <= 80 && (txd !== 1'b0 || busy !== 1'b1)) bad++;
        if (s == 40) line_ctrl = 8'h43;
        if (s == 80) line_ctrl = 8'h03;
        if (busy === 1'b0) break;
      end
      chk(bad == 0, "R8", "line low and busy during break", bad, 0);
      chk(s == 160, "R8", "character end tick with break", s, 160);
      @(negedge clk);
      chk(txd === 1'b1 && in_ready === 1'b1, "R8", "line after break released",
          int'({txd, in_ready}), 3);
      @(negedge clk);
      line_ctrl = 8'h40;
      @(negedge clk);
      chk(txd === 1'b0, "R8", "break on idle line", int'(txd), 0);
      line_ctrl = 8'h00;
      @(negedge clk);
      chk(txd === 1'b1, "R1", "idle after break cleared", int'(txd), 1);
    end
    mon_en = 1;

    chk(q.size() == 0, "R9", "expected characters left", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule